// File: doc/BRIEF.md
# Armed Safety Command Executor

This block sits behind a protocol decoder and turns its decoded commands into actions on the pins around it. It holds a processor reset line, a small bank of external control outputs, and a set of per-channel reset pulses for the link channels of the chip. Together, the processor reset and the four control outputs form five output pins. Each command arrives as a one-cycle valid strobe with a 4-bit code and an argument. The argument selects a control output or a link channel.

Some commands can do harm if a corrupted or stray packet decodes into them. These commands are safety-critical: asserting the processor reset, setting a control output, and resetting every link at once. A safety-critical command runs only after a separate arm command. The arm state is a one-shot. It clears after exactly one safety-critical command has run, so each dangerous action needs its own arm. The remaining commands run at any time and leave the arm state as it was. These are releasing the processor reset, clearing a control output, and resetting a single link.

Command codes: 1 arms. 2 asserts the processor reset (critical). 3 releases it. 4 sets control output `cmdArg` (critical). 5 clears control output `cmdArg`. 6 resets link `cmdArg`. 7 resets all links (critical). Codes 0 and 8 to 15 are undefined.

Top module: `safety_cmd_exec`

## Requirements
- R1: After `rstN` is low, `cpuRstOut`, every bit of `ctrlOut`, every bit of `linkRstOut` and `rejectOut` are 0, and the block is disarmed: a critical command as the first command is rejected.
- R2: Code 1 with `cmdValid` high arms the block. A second code 1 while armed keeps it armed, so exactly one critical command runs afterwards.
- R3: A critical command (code 2, 4 or 7) with a valid argument that arrives while the block is armed executes and disarms the block. A second critical command with no arm in between is rejected.
- R4: A critical command with a valid argument that arrives while the block is disarmed changes no output except `rejectOut`. `rejectOut` is 1 for exactly the one cycle after that command's clock edge.
- R5: Non-critical commands (codes 3, 5, 6) execute whether the block is armed or not, and leave the arm state unchanged.
- R6: Code 2 sets `cpuRstOut` to 1. Code 3 sets it to 0. The level is held until the next such command.
- R7: Code 4 sets `ctrlOut[cmdArg]` to 1 and code 5 clears it. No other bit of `ctrlOut` changes, and the levels are held.
- R8: Code 6 drives `linkRstOut[cmdArg]` high for exactly one clock cycle. All other bits of `linkRstOut` stay 0.
- R9: Code 7 drives every bit of `linkRstOut` high for exactly one clock cycle. The argument is ignored.
- R10: Codes 0 and 8 to 15 are ignored. Codes 4, 5 and 6 with `cmdArg` at or above the number of outputs or links are also ignored. An ignored command changes no output, does not raise `rejectOut`, and does not change the arm state.
- R11: A command acts at the first rising clock edge where `cmdValid` is 1, and its results are visible right after that edge. While `cmdValid` is 0, `cmdCode` and `cmdArg` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one command per high cycle |
| cmdCode | input | 4 | Command code |
| cmdArg | input | ARG_W (4) | Control output or link index |
| cpuRstOut | output | 1 | Processor reset, active high |
| ctrlOut | output | NUM_CTRL (4) | External control outputs |
| linkRstOut | output | NUM_LINKS (4) | Per-link reset pulses |
| rejectOut | output | 1 | One-cycle flag for a critical command refused while disarmed |

## Verification
A wrong arm state shows up only at the next critical command. That command runs when it should have been rejected, or it raises `rejectOut` when it should have run. Either way the error is visible on the cycle after that command. The bench therefore issues many critical commands after non-critical, undefined and out-of-range ones, so a stale or flipped arm bit is exposed within a few commands. Wrong output latches or a link pulse that is too wide show on the first cycle after the command, or on the idle cycle after it.

// File: rtl/safety_cmd_pkg.sv
package safety_cmd_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_NONE      = 4'd0,
    OP_ARM       = 4'd1,
    OP_CPU_HOLD  = 4'd2,
    OP_CPU_FREE  = 4'd3,
    OP_PIN_SET   = 4'd4,
    OP_PIN_CLR   = 4'd5,
    OP_LINK_ONE  = 4'd6,
    OP_LINK_ALL  = 4'd7
  } cmdOp_e;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic cpuRstSet;
    logic cpuRstClr;
    logic ctrlSet;
    logic ctrlClr;
    logic linkOne;
    logic linkAll;
  } execStrobes_t;

  function automatic logic opIsCritical(cmdOp_e op);
    return (op == OP_CPU_HOLD) || (op == OP_PIN_SET) || (op == OP_LINK_ALL);
  endfunction

endpackage

// File: rtl/safety_cmd_ctrl.sv
module safety_cmd_ctrl
  import safety_cmd_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ARG_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic [ARG_W-1:0]  cmdArg,
  output execStrobes_t      strobes,
  output logic              rejectOut
);

  cmdOp_e op;
  logic   codeKnown;
  logic   argInRange;
  logic   accepted;
  logic   critical;
  logic   fire;
  logic   rejectNext;
  logic   armed;
  logic   armedNext;

  assign op = cmdOp_e'(cmdCode);

  always_comb begin
    codeKnown  = 1'b0;
    argInRange = 1'b1;
    unique case (op)
      OP_ARM, OP_CPU_HOLD, OP_CPU_FREE, OP_LINK_ALL: codeKnown = 1'b1;
      OP_PIN_SET, OP_PIN_CLR: begin
        codeKnown  = 1'b1;
        argInRange = (int'(cmdArg) < NUM_CTRL);
      end
      OP_LINK_ONE: begin
        codeKnown  = 1'b1;
        argInRange = (int'(cmdArg) < NUM_LINKS);
      end
      default: codeKnown = 1'b0;
    endcase
  end

  assign accepted   = cmdValid && codeKnown && argInRange;
  assign critical   = opIsCritical(op);
  assign fire       = accepted && (!critical || armed) && (op != OP_ARM);
  assign rejectNext = accepted && critical && !armed;

  always_comb begin
    armedNext = armed;
    if (accepted && op == OP_ARM) begin
      armedNext = 1'b1;
    end else if (fire && critical) begin
      armedNext = 1'b0;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.cpuRstSet = fire && (op == OP_CPU_HOLD);
    strobes.cpuRstClr = fire && (op == OP_CPU_FREE);
    strobes.ctrlSet   = fire && (op == OP_PIN_SET);
    strobes.ctrlClr   = fire && (op == OP_PIN_CLR);
    strobes.linkOne   = fire && (op == OP_LINK_ONE);
    strobes.linkAll   = fire && (op == OP_LINK_ALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      rejectOut <= 1'b0;
    end else begin
      armed     <= armedNext;
      rejectOut <= rejectNext;
    end
  end

  // R4
  reject_needs_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectOut |-> (!$past(armed) && $past(cmdValid)));

  // R2
  arm_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(cmdValid && cmdCode == OP_ARM));

  // R3
  arm_fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(cmdValid && opIsCritical(cmdOp_e'(cmdCode))));

  // R5
  noncrit_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == OP_CPU_FREE || cmdCode == OP_PIN_CLR || cmdCode == OP_LINK_ONE))
      |=> $stable(armed));

  // R10
  unknown_code_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == OP_NONE || cmdCode > OP_LINK_ALL)) |=> ($stable(armed) && !rejectOut));

endmodule

// File: rtl/safety_cmd_datapath.sv
module safety_cmd_datapath
  import safety_cmd_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ARG_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  execStrobes_t         strobes,
  input  logic [ARG_W-1:0]     cmdArg,
  output logic                 cpuRstOut,
  output logic [NUM_CTRL-1:0]  ctrlOut,
  output logic [NUM_LINKS-1:0] linkRstOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRstOut <= 1'b0;
    end else if (strobes.cpuRstSet) begin
      cpuRstOut <= 1'b1;
    end else if (strobes.cpuRstClr) begin
      cpuRstOut <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    logic hit;
    assign hit = (cmdArg == ARG_W'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlOut[c] <= 1'b0;
      end else if (strobes.ctrlSet && hit) begin
        ctrlOut[c] <= 1'b1;
      end else if (strobes.ctrlClr && hit) begin
        ctrlOut[c] <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    logic hit;
    assign hit = (cmdArg == ARG_W'(l));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        linkRstOut[l] <= 1'b0;
      end else begin
        linkRstOut[l] <= strobes.linkAll || (strobes.linkOne && hit);
      end
    end
  end

  // R6
  cpu_rst_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRstOut) |-> $past(strobes.cpuRstSet));

  // R6
  cpu_rst_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRstOut) |-> $past(strobes.cpuRstClr));

  // R7
  ctrl_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlOut ^ $past(ctrlOut)));

  // R8
  link_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|linkRstOut) |-> $past(strobes.linkOne || strobes.linkAll));

  // R8
  link_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.linkAll) |-> $onehot0(linkRstOut));

endmodule

// File: rtl/safety_cmd_exec.sv
module safety_cmd_exec
  import safety_cmd_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ARG_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [CODE_W-1:0]    cmdCode,
  input  logic [ARG_W-1:0]     cmdArg,
  output logic                 cpuRstOut,
  output logic [NUM_CTRL-1:0]  ctrlOut,
  output logic [NUM_LINKS-1:0] linkRstOut,
  output logic                 rejectOut
);

  execStrobes_t strobes;

  safety_cmd_ctrl #(
    .NUM_LINKS (NUM_LINKS),
    .NUM_CTRL  (NUM_CTRL),
    .ARG_W     (ARG_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .cmdArg    (cmdArg),
    .strobes   (strobes),
    .rejectOut (rejectOut)
  );

  safety_cmd_datapath #(
    .NUM_LINKS (NUM_LINKS),
    .NUM_CTRL  (NUM_CTRL),
    .ARG_W     (ARG_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdArg     (cmdArg),
    .cpuRstOut  (cpuRstOut),
    .ctrlOut    (ctrlOut),
    .linkRstOut (linkRstOut)
  );

  // R11
  idle_no_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (linkRstOut == '0 && !rejectOut && $stable(cpuRstOut) && $stable(ctrlOut)));

  // R4
  reject_holds_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectOut |-> ($stable(cpuRstOut) && $stable(ctrlOut) && linkRstOut == '0));

endmodule

// File: tb/test_safety_cmd_exec.sv
module test_safety_cmd_exec;

  localparam int NUM_LINKS = 4;
  localparam int NUM_CTRL  = 4;
  localparam int ARG_W     = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 cmdValid = 1'b0;
  logic [3:0]           cmdCode = '0;
  logic [ARG_W-1:0]     cmdArg = '0;
  logic                 cpuRstOut;
  logic [NUM_CTRL-1:0]  ctrlOut;
  logic [NUM_LINKS-1:0] linkRstOut;
  logic                 rejectOut;

  int checks = 0;
  int fails  = 0;

  bit                 expArmed = 1'b0;
  bit                 expCpu = 1'b0;
  bit [NUM_CTRL-1:0]  expCtrl = '0;
  bit [NUM_LINKS-1:0] expLink = '0;
  bit                 expReject = 1'b0;

  always #4 clk = ~clk;

  safety_cmd_exec #(
    .NUM_LINKS (NUM_LINKS),
    .NUM_CTRL  (NUM_CTRL),
    .ARG_W     (ARG_W)
  ) i_safety_cmd_exec (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdArg     (cmdArg),
    .cpuRstOut  (cpuRstOut),
    .ctrlOut    (ctrlOut),
    .linkRstOut (linkRstOut),
    .rejectOut  (rejectOut)
  );

  function automatic bit isCrit(int code);
    return code == 2 || code == 4 || code == 7;
  endfunction

  function automatic bit isValidCmd(int code, int arg);
    if (code < 1 || code > 7) return 1'b0;
    if ((code == 4 || code == 5) && arg >= NUM_CTRL) return 1'b0;
    if (code == 6 && arg >= NUM_LINKS) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string reqFor(int code, int arg, bit armedNow);
    if (!isValidCmd(code, arg)) return "R10";
    if (code == 1) return "R2";
    if (isCrit(code)) return armedNow ? "R3" : "R4";
    return "R5";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, "cpuRstOut", int'(cpuRstOut), int'(expCpu));
    check(req, "ctrlOut", int'(ctrlOut), int'(expCtrl));
    check(req, "linkRstOut", int'(linkRstOut), int'(expLink));
    check(req, "rejectOut", int'(rejectOut), int'(expReject));
  endtask

  // Model update for one command presented with cmdValid high.
  task automatic model(int code, int arg);
    expLink   = '0;
    expReject = 1'b0;
    if (!isValidCmd(code, arg)) return;
    if (code == 1) begin
      expArmed = 1'b1;
      return;
    end
    if (isCrit(code) && !expArmed) begin
      expReject = 1'b1;
      return;
    end
    if (isCrit(code)) expArmed = 1'b0;
    case (code)
      2: expCpu = 1'b1;
      3: expCpu = 1'b0;
      4: expCtrl[arg] = 1'b1;
      5: expCtrl[arg] = 1'b0;
      6: expLink[arg] = 1'b1;
      7: expLink = '1;
      default: ;
    endcase
  endtask

  // Called at a falling edge. Issues the command, checks after its edge,
  // then holds one idle cycle (with noise on code and argument) and checks
  // that pulses have ended (R8, R9, R4 width; R11 idle).
  task automatic doCmd(int code, int arg, string tag);
    string req;
    req = (tag != "") ? tag : reqFor(code, arg, expArmed);
    cmdValid = 1'b1;
    cmdCode  = 4'(code);
    cmdArg   = ARG_W'(arg);
    model(code, arg);
    @(negedge clk);
    checkAll(req);
    cmdValid = 1'b0;
    cmdCode  = 4'($urandom_range(0, 15));
    cmdArg   = ARG_W'($urandom_range(0, 15));
    expLink   = '0;
    expReject = 1'b0;
    @(negedge clk);
    checkAll((tag != "") ? {tag, "/R11"} : "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // Disarmed after reset: first critical command refused.
    doCmd(2, 0, "R1");
    doCmd(4, 1, "R4");
    doCmd(7, 0, "R4");

    // Double arm, then one critical runs, the next is refused.
    doCmd(1, 0, "R2");
    doCmd(1, 5, "R2");
    doCmd(2, 0, "R6");
    doCmd(4, 1, "R3");
    doCmd(3, 0, "R6");

    // Non-critical commands while armed leave the arm in place.
    doCmd(1, 0, "R2");
    doCmd(6, 2, "R8");
    doCmd(5, 0, "R5");
    doCmd(4, 3, "R7");
    doCmd(4, 2, "R3");
    doCmd(5, 3, "R7");

    // Reset-all link pulse.
    doCmd(1, 0, "R2");
    doCmd(7, 9, "R9");
    doCmd(6, 0, "R8");
    doCmd(6, 3, "R8");

    // Ignored commands keep the arm.
    doCmd(1, 0, "R2");
    doCmd(4, 9, "R10");
    doCmd(6, 4, "R10");
    doCmd(0, 0, "R10");
    doCmd(12, 1, "R10");
    doCmd(15, 2, "R10");
    doCmd(4, 0, "R10");
    doCmd(5, 0, "R7");

    // Constrained random mix, arm commands frequent.
    for (int n = 0; n < 400; n++) begin
      int pick;
      int code;
      int arg;
      pick = $urandom_range(0, 11);
      code = (pick > 7) ? 1 : pick;
      if ($urandom_range(0, 19) == 0) code = $urandom_range(8, 15);
      arg  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 3);
      doCmd(code, arg, "");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule